// File: doc/BRIEF.md
# Serial Interrupt Host Frame Controller

This block is the host end of a single-wire, open-drain style serial interrupt bus that runs on the bus clock. The wire is modelled as three signals: an output enable, the value the host drives while enabled, and the level seen on the wire. A cycle on the bus begins with a Start Frame. The host can open it on its own request. In Quiet mode, an agent can also open it by pulling the idle wire low for one clock, after which the host takes over the low drive. The low pulse lasts a programmable number of clocks. It is followed by one clock driven high and then a release of the wire.

After the Start Frame the block counts a parameterised number of data slots. Each slot is three clocks long: sample, recovery and turn-around. The host never drives during a slot. The wire level in the sample clock of each slot is captured into one bit of an interrupt/data vector.

The cycle ends with a Stop Frame. Its low width tells the agents the mode of the next cycle: two clocks means Quiet, three means Continuous. One driven-high recovery clock and one released turn-around clock follow. The captured vector is then published with a one-clock valid strobe, and the bus mode takes the value the Stop Frame encoded.

Top module: `serirq_host_ctrl`

## Requirements
- R1: While reset is held and in the first clock after it, line_oe is 0, vec_valid is 0, busy is 0 and quiet_mode is 0 (Continuous mode).
- R2: A host_start_req seen while idle makes the host drive the wire low for W+1 consecutive clocks, where W is start_width clamped to the range 3..7 (values 0, 1 and 2 act as 3). The whole low pulse is therefore 4 to 8 clocks.
- R3: In Quiet mode, a low level on line_in while the host is idle and not driving counts as an agent start. The host drives low from the next clock for exactly W clocks, so the total low pulse including the agent's clock is W+1.
- R4: Right after the Start Frame low drive, the host drives the wire high (line_oe=1, line_out=1) for exactly one clock and then releases it (line_oe=0).
- R5: NUM_SLOTS slots of three released clocks each follow. The wire level in the first clock of slot i is stored in irq_vec bit i, where slot 0 is the first slot after the Start Frame and bit 0 is the LSB.
- R6: The Stop Frame low drive lasts 2 clocks when next_quiet is 1 and 3 clocks when it is 0. It is followed by one clock driven high and then one released clock. next_quiet is taken at the clock edge that ends the last slot.
- R7: vec_valid is high for exactly one clock: the clock after the Stop Frame's released clock. irq_vec shows the new vector in that clock and holds it until the next strobe.
- R8: quiet_mode changes only in the clock in which vec_valid is high, and takes the mode encoded by the Stop Frame width. Changing next_quiet while idle has no effect on quiet_mode.
- R9: In Continuous mode (quiet_mode=0), a low level from an agent on the idle wire does not start a cycle: line_oe and busy stay 0.
- R10: busy is high from the first Start Frame low clock through the Stop Frame's released clock. host_start_req during that time neither disturbs the cycle nor queues a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_width | input | 3 | Host low-drive count for a Start Frame, clamped to 3..7 |
| next_quiet | input | 1 | Mode to announce in the Stop Frame: 1 Quiet, 0 Continuous |
| host_start_req | input | 1 | Host request to open a cycle while idle |
| line_in | input | 1 | Level seen on the wire |
| line_oe | output | 1 | Host drives the wire when 1 |
| line_out | output | 1 | Value driven when line_oe is 1 |
| irq_vec | output | NUM_SLOTS | Captured slot levels, bit i from slot i |
| vec_valid | output | 1 | One-clock strobe marking a new irq_vec |
| quiet_mode | output | 1 | Current bus mode: 1 Quiet, 0 Continuous |
| busy | output | 1 | A serial interrupt cycle is in progress |

## Verification
A wrong frame counter shows up at the ports at once as a Start or Stop low pulse of the wrong length, or as the wire driven during a slot. Both appear within the same cycle on the bus. A slot index that slips by one shifts every captured bit, and this is visible in irq_vec at the next valid strobe. A mode register that updates at the wrong time, or to the wrong value, shows up on the next agent start: it is either honoured when it should be ignored, or ignored when it should be honoured.

// File: rtl/serirq_pkg.sv
// Shared types and constants for the serial interrupt host controller.
// Assumes the wire idles high through an external pull-up.
package serirq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START_LO,
        ST_START_HI,
        ST_SLOT,
        ST_STOP_LO,
        ST_STOP_REC,
        ST_STOP_TA
    } frame_st_e;

    localparam int unsigned START_MIN      = 3;
    localparam int unsigned START_MAX      = 7;
    localparam int unsigned SLOT_PHASES    = 3;
    localparam int unsigned STOP_LO_QUIET  = 2;
    localparam int unsigned STOP_LO_CONT   = 3;
endpackage

// File: rtl/serirq_frame_fsm.sv
// Frame sequencer: detects or issues the Start Frame, walks the data slots
// and emits the Stop Frame. Assumes start_width is stable while a Start Frame
// is being opened. Drives the wire controls straight from registered state.
module serirq_frame_fsm
    import serirq_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 17,
    localparam int unsigned SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        start_width,
    input  logic              next_quiet,
    input  logic              host_start_req,
    input  logic              line_in,
    input  logic              quiet_mode,
    output logic              line_oe,
    output logic              line_out,
    output logic              sample_en,
    output logic [SLOT_W-1:0] slot_idx,
    output logic              cycle_done,
    output logic              stop_quiet,
    output logic              busy
);
    frame_st_e   state;
    logic [2:0]  cnt;
    logic [1:0]  phase;
    logic [2:0]  width_eff;
    logic        agent_start;

    // Clamp the programmed host drive count into its legal range.
    always_comb begin
        if (start_width < 3'(START_MIN)) width_eff = 3'(START_MIN);
        else                             width_eff = start_width;
    end

    // An agent start is a low wire while idle and undriven in Quiet mode.
    assign agent_start = (state == ST_IDLE) && quiet_mode && !line_in;

    // Sequence the frames of one serial interrupt cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            phase      <= '0;
            slot_idx   <= '0;
            stop_quiet <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (agent_start) begin
                        state <= ST_START_LO;
                        cnt   <= width_eff - 3'd1;
                    end else if (host_start_req) begin
                        state <= ST_START_LO;
                        cnt   <= width_eff;
                    end
                end
                ST_START_LO: begin
                    if (cnt == 3'd0) state <= ST_START_HI;
                    else             cnt   <= cnt - 3'd1;
                end
                ST_START_HI: begin
                    state    <= ST_SLOT;
                    phase    <= '0;
                    slot_idx <= '0;
                end
                ST_SLOT: begin
                    if (phase == 2'(SLOT_PHASES - 1)) begin
                        phase <= '0;
                        if (slot_idx == SLOT_W'(NUM_SLOTS - 1)) begin
                            state      <= ST_STOP_LO;
                            stop_quiet <= next_quiet;
                            cnt        <= next_quiet ? 3'(STOP_LO_QUIET - 1)
                                                     : 3'(STOP_LO_CONT - 1);
                        end else begin
                            slot_idx <= slot_idx + SLOT_W'(1);
                        end
                    end else begin
                        phase <= phase + 2'd1;
                    end
                end
                ST_STOP_LO: begin
                    if (cnt == 3'd0) state <= ST_STOP_REC;
                    else             cnt   <= cnt - 3'd1;
                end
                ST_STOP_REC: state <= ST_STOP_TA;
                ST_STOP_TA:  state <= ST_IDLE;
                default:     state <= ST_IDLE;
            endcase
        end
    end

    // Decode the wire controls and strobes from the current frame state.
    always_comb begin
        line_oe    = 1'b0;
        line_out   = 1'b1;
        unique case (state)
            ST_START_LO, ST_STOP_LO: begin
                line_oe  = 1'b1;
                line_out = 1'b0;
            end
            ST_START_HI, ST_STOP_REC: begin
                line_oe  = 1'b1;
                line_out = 1'b1;
            end
            default: ;
        endcase
        sample_en  = (state == ST_SLOT) && (phase == 2'd0);
        cycle_done = (state == ST_STOP_TA);
        busy       = (state != ST_IDLE);
    end

    // R4: one high clock after the start low drive, then the wire is released.
    p_start_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START_HI) |=> (state == ST_SLOT && !line_oe));

    // R5: a sample clock is always followed by a non-sample slot clock.
    p_sample_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |=> (state == ST_SLOT && !sample_en));

    // R6: the last stop low clock leads to the driven-high recovery clock.
    p_stop_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP_LO && cnt == 3'd0) |=> (line_oe && line_out));

    // R9: in Continuous mode, only a host request leaves idle.
    p_cont_no_agent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !quiet_mode && !host_start_req) |=> !busy);

    // R10: a request during a cycle does not cut the cycle short.
    p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cycle_done) |=> busy);
endmodule

// File: rtl/serirq_slot_capture.sv
// Slot capture: stores the wire level of each sample clock into a shadow
// vector and publishes it with a one-clock strobe at the end of the cycle.
// Assumes slot_idx is below NUM_SLOTS whenever sample_en is high.
module serirq_slot_capture #(
    parameter int unsigned NUM_SLOTS = 17,
    localparam int unsigned SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sample_en,
    input  logic [SLOT_W-1:0]    slot_idx,
    input  logic                 line_in,
    input  logic                 cycle_done,
    output logic [NUM_SLOTS-1:0] irq_vec,
    output logic                 vec_valid
);
    logic [NUM_SLOTS-1:0] shadow;

    // Record each slot's sampled level at its own bit position.
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)                                      shadow[g] <= 1'b1;
            else if (sample_en && slot_idx == SLOT_W'(g))    shadow[g] <= line_in;
        end
    end

    // Publish the completed vector with a single-clock strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_vec   <= '1;
            vec_valid <= 1'b0;
        end else begin
            vec_valid <= cycle_done;
            if (cycle_done) irq_vec <= shadow;
        end
    end

    // R7: the strobe never lasts two clocks.
    p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);

    // R7: the published vector changes only together with the strobe.
    p_vec_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_valid |-> $stable(irq_vec));
endmodule

// File: rtl/serirq_mode_reg.sv
// Bus mode register: takes the mode encoded by the Stop Frame at the end of
// each cycle. Resets to Continuous mode so the host opens the first cycle.
module serirq_mode_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic cycle_done,
    input  logic stop_quiet,
    output logic quiet_mode
);
    // Update the mode only when a Stop Frame has just finished.
    always_ff @(posedge clk) begin
        if (!rst_n)          quiet_mode <= 1'b0;
        else if (cycle_done) quiet_mode <= stop_quiet;
    end

    // R8: the mode holds steady outside the end of a cycle.
    p_mode_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cycle_done |=> $stable(quiet_mode));
endmodule

// File: rtl/serirq_host_ctrl.sv
// Top of the serial interrupt host frame controller. Joins the frame
// sequencer, the slot capture and the mode register. Assumes line_in is the
// resolved wire level, including the host's own drive.
module serirq_host_ctrl
    import serirq_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 17,
    localparam int unsigned SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           start_width,
    input  logic                 next_quiet,
    input  logic                 host_start_req,
    input  logic                 line_in,
    output logic                 line_oe,
    output logic                 line_out,
    output logic [NUM_SLOTS-1:0] irq_vec,
    output logic                 vec_valid,
    output logic                 quiet_mode,
    output logic                 busy
);
    logic              sample_en;
    logic [SLOT_W-1:0] slot_idx;
    logic              cycle_done;
    logic              stop_quiet;

    serirq_frame_fsm #(.NUM_SLOTS(NUM_SLOTS)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_width    (start_width),
        .next_quiet     (next_quiet),
        .host_start_req (host_start_req),
        .line_in        (line_in),
        .quiet_mode     (quiet_mode),
        .line_oe        (line_oe),
        .line_out       (line_out),
        .sample_en      (sample_en),
        .slot_idx       (slot_idx),
        .cycle_done     (cycle_done),
        .stop_quiet     (stop_quiet),
        .busy           (busy)
    );

    serirq_slot_capture #(.NUM_SLOTS(NUM_SLOTS)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_en  (sample_en),
        .slot_idx   (slot_idx),
        .line_in    (line_in),
        .cycle_done (cycle_done),
        .irq_vec    (irq_vec),
        .vec_valid  (vec_valid)
    );

    serirq_mode_reg u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .cycle_done (cycle_done),
        .stop_quiet (stop_quiet),
        .quiet_mode (quiet_mode)
    );

    // R1: nothing is driven in the first clock after reset.
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!line_oe && !vec_valid && !busy && !quiet_mode));
endmodule

// File: tb/tb_serirq_host_ctrl.sv
`timescale 1ns/1ps
module tb_serirq_host_ctrl;
    localparam int NS = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    start_width = 3'd3;
    logic          next_quiet = 1'b0;
    logic          host_start_req = 1'b0;
    logic          agent_lvl = 1'b1;
    logic          line_in;
    logic          line_oe, line_out, vec_valid, quiet_mode, busy;
    logic [NS-1:0] irq_vec;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    assign line_in = line_oe ? line_out : agent_lvl;

    always #2.5 clk = ~clk;

    serirq_host_ctrl #(.NUM_SLOTS(NS)) dut (
        .clk(clk), .rst_n(rst_n), .start_width(start_width),
        .next_quiet(next_quiet), .host_start_req(host_start_req),
        .line_in(line_in), .line_oe(line_oe), .line_out(line_out),
        .irq_vec(irq_vec), .vec_valid(vec_valid),
        .quiet_mode(quiet_mode), .busy(busy)
    );

    typedef struct packed {
        logic [2:0]    width;
        logic          nq;
        logic          agent;
        logic          mid_req;
        logic [NS-1:0] pat;
    } row_t;

    localparam row_t TABLE [7] = '{
        '{3'd3, 1'b0, 1'b0, 1'b0, 17'h1A5C3},
        '{3'd7, 1'b1, 1'b0, 1'b0, 17'h0FFFF},
        '{3'd5, 1'b1, 1'b1, 1'b0, 17'h10001},
        '{3'd1, 1'b0, 1'b1, 1'b1, 17'h15555},
        '{3'd6, 1'b0, 1'b0, 1'b0, 17'h0AAAA},
        '{3'd0, 1'b1, 1'b0, 1'b0, 17'h00000},
        '{3'd4, 1'b1, 1'b0, 1'b0, 17'h1FFFF}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Run one full cycle on the bus and check every frame of it.
    task automatic run_frame(input row_t r);
        int low = 0;
        int w   = (r.width < 3) ? 3 : int'(r.width);
        start_width = r.width;
        next_quiet  = r.nq;
        if (r.agent) begin
            agent_lvl = 1'b0;
            step();
            agent_lvl = 1'b1;
            low = 1;
        end else begin
            host_start_req = 1'b1;
            step();
            host_start_req = 1'b0;
        end
        for (int g = 0; g < 12 && line_oe && !line_out; g++) begin
            low++;
            step();
        end
        if (r.agent) chk(low == w + 1, "R3 agent start low width", low, w + 1);
        else         chk(low == w + 1, "R2 host start low width", low, w + 1);
        chk(line_oe && line_out, "R4 start high clock", {line_oe, line_out}, 3);
        step();
        chk(!line_oe, "R4 release after start", line_oe, 0);
        for (int k = 0; k < 3 * NS; k++) begin
            if (line_oe || !busy) chk(0, "R5 slot released / R10 busy", {line_oe, busy}, 1);
            if (k % 3 == 0) agent_lvl = r.pat[k / 3];
            if (r.mid_req) host_start_req = 1'b1;
            step();
            agent_lvl = 1'b1;
        end
        host_start_req = 1'b0;
        next_quiet = ~r.nq;
        low = 0;
        for (int g = 0; g < 12 && line_oe && !line_out; g++) begin
            low++;
            step();
        end
        chk(low == (r.nq ? 2 : 3), "R6 stop low width", low, r.nq ? 2 : 3);
        chk(line_oe && line_out, "R6 stop recovery high", {line_oe, line_out}, 3);
        step();
        chk(!line_oe && busy, "R6 stop turn-around released", {line_oe, busy}, 1);
        step();
        chk(vec_valid == 1'b1, "R7 valid strobe", vec_valid, 1);
        chk(irq_vec == r.pat, "R5 captured vector", irq_vec, r.pat);
        chk(quiet_mode == r.nq, "R8 mode from stop width", quiet_mode, r.nq);
        chk(!busy, "R10 busy ends", busy, 0);
        step();
        chk(vec_valid == 1'b0 && irq_vec == r.pat, "R7 strobe one clock, vector held",
            {vec_valid, irq_vec}, r.pat);
        if (r.mid_req) begin
            for (int g = 0; g < 4; g++) begin
                if (line_oe || busy) chk(0, "R10 request during cycle queued", busy, 0);
                step();
            end
            chk(!busy, "R10 no queued cycle", busy, 0);
        end
    endtask

    // Watchdog: a hung run is a failure and still reports the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        step();
        step();
        chk(!line_oe && !vec_valid && !busy && !quiet_mode, "R1 reset state",
            {line_oe, vec_valid, busy, quiet_mode}, 0);
        rst_n = 1'b1;
        step();
        chk(!line_oe && !busy && !quiet_mode, "R1 first clock after reset",
            {line_oe, busy, quiet_mode}, 0);

        // R9: an agent pulse in Continuous mode is ignored.
        agent_lvl = 1'b0;
        step();
        agent_lvl = 1'b1;
        for (int g = 0; g < 5; g++) begin
            if (line_oe || busy) chk(0, "R9 agent start in continuous", {line_oe, busy}, 0);
            step();
        end
        chk(!line_oe && !busy, "R9 still idle", {line_oe, busy}, 0);

        // R8: next_quiet while idle leaves the mode alone.
        next_quiet = 1'b1;
        step();
        step();
        chk(quiet_mode == 1'b0, "R8 next_quiet idle no effect", quiet_mode, 0);

        foreach (TABLE[i]) run_frame(TABLE[i]);

        // R1: a reset in the middle of a cycle returns everything to idle.
        host_start_req = 1'b1;
        step();
        host_start_req = 1'b0;
        step();
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        chk(!line_oe && !busy && !quiet_mode && !vec_valid, "R1 mid-cycle reset",
            {line_oe, busy, quiet_mode, vec_valid}, 0);
        step();
        chk(!line_oe && !busy, "R1 idle after mid-cycle reset", {line_oe, busy}, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule